// File: doc/BRIEF.md
# Tone Guard-Time Steering Controller

This block stands in for the resistor-capacitor timing network that normally sits beside a tone-pair receiver. It watches an early-steer flag, raised by an upstream decoder whenever a valid tone pair is present, together with the 4-bit candidate code that the decoder offers. Before it accepts a tone, the flag must stay high for a programmable present guard time. Before it accepts the next tone, the flag must stay low for a separate, programmable absent guard time. Both guard times are counted in ticks of a prescaled clock, nominally one millisecond.

When a tone qualifies, the block loads its output latch and emits a one-cycle registration strobe. A fixed settle delay later it raises the delayed-steer flag, so the data is stable before the flag. The flag stays high while the tone persists and through dropouts shorter than the absent guard time. It falls when a full absent guard time has elapsed. Only after that can a new tone be registered.

The latched code is presented on a 4-bit bus gated by an output enable. Because the bus is modelled without tri-state drivers, a separate drive-enable output shows when the bus would be driven.

Top module: `tone_steer_ctrl`

## Requirements
- R1: Let N be `on_guard_i` and D be `TICK_DIV`. A tone registers only when `est_i` is sampled high at N*D+1 consecutive rising edges, counted from the first edge that sees it high. The value on `code_i` at the last of those edges is latched and appears on the next cycle. A count of zero behaves as one.
- R2: A burst of `est_i` high that is shorter than the R1 window leaves the latch, `dstd_o` and `reg_stb_o` unchanged.
- R3: Once a tone is registered, the block stays registered, with `dstd_o` held high, for as long as `est_i` stays high.
- R4: `dstd_o` rises exactly `SETTLE_CYC` cycles after the cycle in which the newly latched code first appears.
- R5: `reg_stb_o` is high for exactly one cycle for each registration. That cycle is the first cycle in which the new code is visible.
- R6: Let M be `off_guard_i`. After registration, `dstd_o` falls on the cycle after the M*D+1-th consecutive edge that samples `est_i` low. A shorter dropout followed by `est_i` high again leaves the latch and `dstd_o` unchanged.
- R7: While registered or qualifying absence, changes on `code_i` are not latched and no new registration occurs.
- R8: The latched code is held through a pause until the next registration.
- R9: With `oe_i` high, `q_o` shows the latch and `q_oe_o` is high. With `oe_i` low, `q_o` reads zero and `q_oe_o` is low. The latch still updates while the bus is disabled.
- R10: The present and absent guard counts take effect independently of each other.
- R11: A synchronous reset clears the latch to 0, lowers `dstd_o` and `reg_stb_o`, and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| est_i | input | 1 | Early-steer flag from the tone decoder |
| code_i | input | CODE_W | Candidate code offered by the decoder |
| on_guard_i | input | GUARD_W | Present guard time, in ticks |
| off_guard_i | input | GUARD_W | Absent guard time, in ticks |
| oe_i | input | 1 | Output bus enable |
| q_o | output | CODE_W | Latched code, zero when the bus is released |
| q_oe_o | output | 1 | High when the bus would be driven |
| dstd_o | output | 1 | Delayed-steer flag |
| reg_stb_o | output | 1 | One-cycle strobe on each new registration |

## Verification
After the edge that completes the present window, the latch and the strobe are visible in the next cycle. The delayed-steer flag follows `SETTLE_CYC` cycles after that, and the flag falls one cycle after the edge that completes the absent window. The bench changes inputs on the falling edge and holds each level for an exact number of rising edges. It reads the results on the falling edge right after the edge where a result is due, and on the one before it for the boundary cases. A scoreboard queue pairs every expected registration with its strobe. The monitor also measures the strobe-to-flag distance in cycles.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_QUAL_ON  = 2'd1,
      ST_HELD     = 2'd2,
      ST_QUAL_OFF = 2'd3
   } steer_state_e;
endpackage

// File: rtl/tsc_prescaler.sv
module tsc_prescaler #(
   parameter int TICK_DIV = 250000
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic run,
   output logic tick
);
   localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == CW'(TICK_DIV - 1));

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt <= '0;
      else if (run) begin
         if (cnt == CW'(TICK_DIV - 1))
            cnt <= '0;
         else
            cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tsc_guard_timer.sv
module tsc_guard_timer #(
   parameter int GUARD_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               clr,
   input  logic               tick,
   input  logic [GUARD_W-1:0] limit,
   output logic               expire
);
   logic [GUARD_W-1:0] cnt;
   logic [GUARD_W:0]   nxt;

   assign nxt    = {1'b0, cnt} + 1'b1;
   assign expire = tick && (nxt >= {1'b0, limit});

   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt <= '0;
      else if (tick)
         cnt <= nxt[GUARD_W-1:0];
   end
endmodule

// File: rtl/tsc_settle.sv
module tsc_settle #(
   parameter int SETTLE_CYC = 3000
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic abort,
   output logic flag
);
   generate
      if (SETTLE_CYC == 0) begin : g_direct
         always_ff @(posedge clk) begin
            if (rst || abort)
               flag <= 1'b0;
            else if (start)
               flag <= 1'b1;
         end
      end else begin : g_delay
         localparam int SW = $clog2(SETTLE_CYC + 1);
         logic [SW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst || abort) begin
               cnt  <= '0;
               flag <= 1'b0;
            end else if (start) begin
               cnt  <= SW'(SETTLE_CYC);
               flag <= 1'b0;
            end else if (cnt != '0) begin
               cnt <= cnt - 1'b1;
               if (cnt == SW'(1))
                  flag <= 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/tone_steer_ctrl.sv
module tone_steer_ctrl
   import tsc_pkg::*;
#(
   parameter int CODE_W     = 4,
   parameter int GUARD_W    = 8,
   parameter int TICK_DIV   = 250000,
   parameter int SETTLE_CYC = 3000
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               est_i,
   input  logic [CODE_W-1:0]  code_i,
   input  logic [GUARD_W-1:0] on_guard_i,
   input  logic [GUARD_W-1:0] off_guard_i,
   input  logic               oe_i,
   output logic [CODE_W-1:0]  q_o,
   output logic               q_oe_o,
   output logic               dstd_o,
   output logic               reg_stb_o
);
   generate
      if (CODE_W < 1 || GUARD_W < 1 || TICK_DIV < 1 || SETTLE_CYC < 0) begin : g_bad_cfg
         $error("tone_steer_ctrl: illegal parameter set");
      end
   endgenerate

   steer_state_e       state_q;
   logic [CODE_W-1:0]  code_q;
   logic               tick, expire, clr, run, win, lose;
   logic [GUARD_W-1:0] limit;

   // one prescaler and one timer are shared by both qualify phases
   always_comb begin
      clr   = (state_q == ST_IDLE && est_i) || (state_q == ST_HELD && !est_i);
      run   = (state_q == ST_QUAL_ON) || (state_q == ST_QUAL_OFF);
      limit = (state_q == ST_QUAL_ON) ? on_guard_i : off_guard_i;
      win   = (state_q == ST_QUAL_ON) && est_i && expire;
      lose  = (state_q == ST_QUAL_OFF) && !est_i && expire;
   end

   tsc_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
      .clk(clk), .rst(rst), .clr(clr), .run(run), .tick(tick)
   );

   tsc_guard_timer #(.GUARD_W(GUARD_W)) u_tmr (
      .clk(clk), .rst(rst), .clr(clr), .tick(tick), .limit(limit), .expire(expire)
   );

   tsc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk(clk), .rst(rst), .start(win), .abort(lose), .flag(dstd_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         code_q    <= '0;
         reg_stb_o <= 1'b0;
      end else begin
         reg_stb_o <= win;
         if (win)
            code_q <= code_i;
         unique case (state_q)
            ST_IDLE:     if (est_i) state_q <= ST_QUAL_ON;
            ST_QUAL_ON:  if (!est_i) state_q <= ST_IDLE;
                         else if (expire) state_q <= ST_HELD;
            ST_HELD:     if (!est_i) state_q <= ST_QUAL_OFF;
            ST_QUAL_OFF: if (est_i) state_q <= ST_HELD;
                         else if (expire) state_q <= ST_IDLE;
            default:     state_q <= ST_IDLE;
         endcase
      end
   end

   assign q_o    = oe_i ? code_q : '0;
   assign q_oe_o = oe_i;
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk
   import tsc_pkg::*;
#(
   parameter int CODE_W     = 4,
   parameter int SETTLE_CYC = 3000
) (
   input logic              clk,
   input logic              rst,
   input logic              est_i,
   input steer_state_e      state_q,
   input logic [CODE_W-1:0] code_q,
   input logic              dstd_o,
   input logic              reg_stb_o
);
   // R2
   latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !reg_stb_o |-> $stable(code_q));

   // R5
   stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      reg_stb_o |=> !reg_stb_o);

   // R4
   stb_before_flag_chk: assert property (@(posedge clk) disable iff (rst)
      reg_stb_o |-> (dstd_o == (SETTLE_CYC == 0)));

   // R6
   flag_fall_idle_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(dstd_o) |-> (state_q == ST_IDLE));

   // R7
   no_reentry_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_HELD || state_q == ST_QUAL_OFF) |=> !reg_stb_o);

   // R3
   held_stay_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_HELD && est_i) |=> (state_q == ST_HELD));

   // R11
   reset_state_chk: assert property (@(posedge clk)
      $past(rst) |-> (code_q == '0 && !dstd_o && !reg_stb_o && state_q == ST_IDLE));
endmodule

bind tone_steer_ctrl tsc_chk #(.CODE_W(CODE_W), .SETTLE_CYC(SETTLE_CYC)) u_tsc_chk (
   .clk(clk), .rst(rst), .est_i(est_i), .state_q(state_q),
   .code_q(code_q), .dstd_o(dstd_o), .reg_stb_o(reg_stb_o)
);

// File: tb/test_tone_steer_ctrl.sv
module test_tone_steer_ctrl;
   localparam int D  = 4;
   localparam int S  = 3;
   localparam int CW = 4;
   localparam int GW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          est = 1'b0;
   logic          oe  = 1'b1;
   logic [CW-1:0] code = '0;
   logic [GW-1:0] on_g = 8'd3;
   logic [GW-1:0] off_g = 8'd5;
   logic [CW-1:0] q;
   logic          q_oe, dstd, stb;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int stb_cyc = -1;
   logic dstd_prev = 1'b0;
   logic [CW-1:0] exp_q[$];
   logic [CW-1:0] mon_e;

   tone_steer_ctrl #(.CODE_W(CW), .GUARD_W(GW), .TICK_DIV(D), .SETTLE_CYC(S)) i_tone_steer_ctrl (
      .clk(clk), .rst(rst), .est_i(est), .code_i(code), .on_guard_i(on_g),
      .off_guard_i(off_g), .oe_i(oe), .q_o(q), .q_oe_o(q_oe), .dstd_o(dstd), .reg_stb_o(stb)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic drive(input logic e, input logic [CW-1:0] c, input int n);
      est  = e;
      code = c;
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops expected registrations and times the flag
   always @(negedge clk) begin
      if (rst) begin
         dstd_prev = 1'b0;
         stb_cyc   = -1;
      end else begin
         if (stb) begin
            if (exp_q.size() == 0)
               chk(1'b0, "R2 unexpected registration", int'(q), -1);
            else begin
               mon_e = exp_q.pop_front();
               if (oe) chk(q == mon_e, "R1 latched code", int'(q), int'(mon_e));
            end
            stb_cyc = cyc;
         end
         if (dstd && !dstd_prev)
            chk(stb_cyc >= 0 && cyc - stb_cyc == S, "R4 settle delay", cyc - stb_cyc, S);
         dstd_prev = dstd;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(q == 0 && !dstd && !stb, "R11 reset state", int'(q), 0);
      rst = 1'b0;
      @(negedge clk);
      // R2: one sample short of the window
      drive(1'b1, 4'd5, 12);
      drive(1'b0, 4'd5, 3);
      chk(dstd == 1'b0, "R2 flag after short burst", int'(dstd), 0);
      chk(q == 0, "R2 latch after short burst", int'(q), 0);
      // R1/R5: exact window
      exp_q.push_back(4'd5);
      drive(1'b1, 4'd5, 13);
      chk(q == 5, "R1 exact window", int'(q), 5);
      chk(stb == 1'b1, "R5 strobe with data", int'(stb), 1);
      chk(dstd == 1'b0, "R4 flag after data", int'(dstd), 0);
      // R3/R7: held, code change ignored
      drive(1'b1, 4'd9, 20);
      chk(q == 5, "R7 code change ignored", int'(q), 5);
      chk(dstd == 1'b1, "R3 held while tone present", int'(dstd), 1);
      // R6: short dropout
      drive(1'b0, 4'd9, 20);
      drive(1'b1, 4'd9, 5);
      chk(dstd == 1'b1, "R6 short dropout flag", int'(dstd), 1);
      chk(q == 5, "R6 short dropout latch", int'(q), 5);
      // R6: absent window boundary
      drive(1'b0, 4'd9, 20);
      chk(dstd == 1'b1, "R6 one short of absent window", int'(dstd), 1);
      drive(1'b0, 4'd9, 1);
      chk(dstd == 1'b0, "R6 flag falls", int'(dstd), 0);
      drive(1'b0, 4'd9, 10);
      chk(q == 5, "R8 held through pause", int'(q), 5);
      // R10: independent counts
      on_g  = 8'd1;
      off_g = 8'd2;
      exp_q.push_back(4'd12);
      drive(1'b1, 4'd12, 5);
      chk(q == 12, "R10 short present count", int'(q), 12);
      drive(1'b0, 4'd12, 8);
      chk(dstd == 1'b1, "R10 absent not yet expired", int'(dstd), 1);
      drive(1'b0, 4'd12, 1);
      chk(dstd == 1'b0, "R10 absent expiry", int'(dstd), 0);
      // R1: zero count acts as one
      on_g = 8'd0;
      drive(1'b1, 4'd7, 4);
      drive(1'b0, 4'd7, 2);
      chk(q == 12, "R1 zero count short burst", int'(q), 12);
      exp_q.push_back(4'd7);
      drive(1'b1, 4'd7, 5);
      chk(q == 7, "R1 zero count acts as one", int'(q), 7);
      drive(1'b0, 4'd7, 9);
      chk(dstd == 1'b0, "R6 idle after zero-count tone", int'(dstd), 0);
      // R9: bus released, latch still updates
      oe = 1'b0;
      @(negedge clk);
      chk(q == 0 && !q_oe, "R9 bus released", int'(q), 0);
      on_g  = 8'd3;
      off_g = 8'd5;
      exp_q.push_back(4'd10);
      drive(1'b1, 4'd10, 13);
      chk(q == 0 && !q_oe, "R9 released while latching", int'(q), 0);
      drive(1'b1, 4'd10, 5);
      oe = 1'b1;
      @(negedge clk);
      chk(q == 10 && q_oe, "R9 latch updated while disabled", int'(q), 10);
      // R11: reset while registered
      rst = 1'b1;
      drive(1'b1, 4'd10, 2);
      chk(q == 0 && !dstd, "R11 reset while registered", int'(q), 0);
      rst = 1'b0;
      drive(1'b0, 4'd0, 3);
      chk(exp_q.size() == 0, "R1 no missed registration", exp_q.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule